// File: doc/BRIEF.md
# Programmable Flag Offset Sequencer

This block keeps the two thresholds that a FIFO's almost-empty and almost-full flag logic compares against. Each threshold is 16 bits wide and is stored as a pair of bytes, so the block holds four byte registers in total. Software or a host loads them one byte per write-clock edge from the FIFO's 9-bit input bus. A state machine picks which byte is written next. The same bytes can be read back one per read-clock edge through a second state machine of the same kind, which runs in the read-clock domain.

The write pointer and the read pointer each step through four named states: `SEL_E_LO` (almost-empty threshold, low byte), `SEL_E_HI` (almost-empty threshold, high byte), `SEL_F_LO` (almost-full threshold, low byte) and `SEL_F_HI` (almost-full threshold, high byte). A pointer has two transitions. The *advance* transition moves it to the next state in that list, and the *wrap* transition moves it from `SEL_F_HI` back to `SEL_E_LO`. A pointer moves only on an access. At any other time it holds, so a load can be split across several short bursts.

The FIFO data path uses `ofs_cycle` to tell an offset access apart from an ordinary FIFO access. Each combined threshold is cut down to the FIFO address width before it is handed to the flag comparators.

Top module: `offset_seq`

## Requirements
- R1: A write step is a rising `wclk` edge with `load_n`=0 and `wen1_n`=0. Write steps fill the registers in the order E_LO, E_HI, F_LO, F_HI. The step after F_HI writes E_LO again.
- R2: On a write step, `din[7:0]` is stored into the register that the write pointer selects. The change is visible on `empty_ofs`/`full_ofs` after that edge.
- R3: Two cases leave every offset register unchanged: `load_n`=0 with `wen1_n`=1, and `load_n`=1 with `wen1_n`=0 (an ordinary FIFO write).
- R4: A load that stops part-way (`load_n` raised) resumes at the next register in the order, not at E_LO.
- R5: A read step is a rising `rclk` edge with `load_n`=0, `ren1_n`=0 and `ren2_n`=0. It places the selected register on `rd_data` and advances the read pointer in the order E_LO, E_HI, F_LO, F_HI, then wraps to E_LO. At any other time `rd_data` holds. A read step and a write step at the same time are not supported.
- R6: While `rst_n`=0, both thresholds are 7, `rd_data` is 0, and both pointers return to `SEL_E_LO`.
- R7: Only the lower 8 bits of `din` are stored. `rd_data[8]` is always 0.
- R8: `empty_ofs` and `full_ofs` are `{high byte, low byte}` truncated to `ADDR_W` bits. High-byte bits above that width have no effect on the outputs but are still stored and read back.
- R9: `ofs_cycle` is 1 exactly while `load_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_n | input | 1 | Offset-access select, active low |
| wen1_n | input | 1 | Write enable, active low |
| ren1_n | input | 1 | Read enable 1, active low |
| ren2_n | input | 1 | Read enable 2, active low |
| din | input | 9 | Input data bus |
| empty_ofs | output | ADDR_W | Almost-empty threshold for the flag logic |
| full_ofs | output | ADDR_W | Almost-full threshold for the flag logic |
| rd_data | output | 9 | Offset readback data |
| ofs_cycle | output | 1 | Current cycle is an offset access |

## Verification
The hardest case to reach is a pointer sitting in the middle of the sequence after a partial load. That position is only visible later, through which register the next access lands in. The stimulus loads one or two bytes, spends idle, no-op and ordinary-FIFO cycles in between, and then loads again. The resulting threshold values show whether the pointer held its place. Reset is applied with both pointers away from `SEL_E_LO`, and the first write and read afterwards show that both pointers returned to the start.

// File: rtl/offset_seq_pkg.sv
package offset_seq_pkg;

    typedef enum logic [1:0] {
        SEL_E_LO = 2'd0,
        SEL_E_HI = 2'd1,
        SEL_F_LO = 2'd2,
        SEL_F_HI = 2'd3
    } sel_t;

    function automatic sel_t sel_next(input sel_t cur);
        sel_t nxt;
        unique case (cur)
            SEL_E_LO: nxt = SEL_E_HI;
            SEL_E_HI: nxt = SEL_F_LO;
            SEL_F_LO: nxt = SEL_F_HI;
            SEL_F_HI: nxt = SEL_E_LO;
            default:  nxt = SEL_E_LO;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/offs_wr_seq.sv
module offs_wr_seq
    import offset_seq_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int DATA_W  = 9,
    parameter int NUM_REG = 4,
    parameter logic [2*BYTE_W-1:0] DEF_OFS = 16'd7
) (
    input  logic                          wclk,
    input  logic                          rst_n,
    input  logic                          wr_step,
    input  logic [DATA_W-1:0]             din,
    output sel_t                          wr_sel,
    output logic [NUM_REG-1:0][BYTE_W-1:0] regs
);

    sel_t sel_q, sel_d;

    // state register
    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) sel_q <= SEL_E_LO;
        else        sel_q <= sel_d;
    end

    // advance / wrap on each write step, hold otherwise
    always_comb begin
        sel_d = wr_step ? sel_next(sel_q) : sel_q;
    end

    // outputs: byte registers
    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            regs[SEL_E_LO] <= DEF_OFS[BYTE_W-1:0];
            regs[SEL_E_HI] <= DEF_OFS[2*BYTE_W-1:BYTE_W];
            regs[SEL_F_LO] <= DEF_OFS[BYTE_W-1:0];
            regs[SEL_F_HI] <= DEF_OFS[2*BYTE_W-1:BYTE_W];
        end else if (wr_step) begin
            regs[sel_q] <= din[BYTE_W-1:0];
        end
    end

    assign wr_sel = sel_q;

endmodule

// File: rtl/offs_rd_seq.sv
module offs_rd_seq
    import offset_seq_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int DATA_W  = 9,
    parameter int NUM_REG = 4
) (
    input  logic                           rclk,
    input  logic                           rst_n,
    input  logic                           rd_step,
    input  logic [NUM_REG-1:0][BYTE_W-1:0] regs,
    output sel_t                           rd_sel,
    output logic [DATA_W-1:0]              rd_data
);

    localparam int PAD_W = DATA_W - BYTE_W;

    sel_t sel_q, sel_d;

    // state register
    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) sel_q <= SEL_E_LO;
        else        sel_q <= sel_d;
    end

    always_comb begin
        sel_d = rd_step ? sel_next(sel_q) : sel_q;
    end

    // outputs: readback register
    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n)       rd_data <= '0;
        else if (rd_step) rd_data <= {{PAD_W{1'b0}}, regs[sel_q]};
    end

    assign rd_sel = sel_q;

endmodule

// File: rtl/offset_seq.sv
module offset_seq
    import offset_seq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 9,
    parameter int BYTE_W = 8
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic              wen1_n,
    input  logic              ren1_n,
    input  logic              ren2_n,
    input  logic [DATA_W-1:0] din,
    output logic [ADDR_W-1:0] empty_ofs,
    output logic [ADDR_W-1:0] full_ofs,
    output logic [DATA_W-1:0] rd_data,
    output logic              ofs_cycle
);

    localparam int NUM_REG = 4;
    localparam int OFS_W   = 2 * BYTE_W;

    logic [NUM_REG-1:0][BYTE_W-1:0] regs;
    logic [OFS_W-1:0] e_full, f_full;
    logic wr_step, rd_step;
    sel_t wr_sel, rd_sel;

    assign wr_step   = !load_n && !wen1_n;
    assign rd_step   = !load_n && !ren1_n && !ren2_n;
    assign ofs_cycle = !load_n;

    offs_wr_seq #(
        .BYTE_W (BYTE_W),
        .DATA_W (DATA_W),
        .NUM_REG(NUM_REG),
        .DEF_OFS(OFS_W'(7))
    ) u_wr (
        .wclk   (wclk),
        .rst_n  (rst_n),
        .wr_step(wr_step),
        .din    (din),
        .wr_sel (wr_sel),
        .regs   (regs)
    );

    offs_rd_seq #(
        .BYTE_W (BYTE_W),
        .DATA_W (DATA_W),
        .NUM_REG(NUM_REG)
    ) u_rd (
        .rclk   (rclk),
        .rst_n  (rst_n),
        .rd_step(rd_step),
        .regs   (regs),
        .rd_sel (rd_sel),
        .rd_data(rd_data)
    );

    assign e_full = {regs[SEL_E_HI], regs[SEL_E_LO]};
    assign f_full = {regs[SEL_F_HI], regs[SEL_F_LO]};

    generate
        if (ADDR_W < OFS_W) begin : g_trunc
            assign empty_ofs = e_full[ADDR_W-1:0];
            assign full_ofs  = f_full[ADDR_W-1:0];
        end else begin : g_pad
            assign empty_ofs = ADDR_W'(e_full);
            assign full_ofs  = ADDR_W'(f_full);
        end
    endgenerate

endmodule

// File: rtl/offset_seq_chk.sv
module offset_seq_chk
    import offset_seq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 9
) (
    input logic              wclk,
    input logic              rclk,
    input logic              rst_n,
    input logic              load_n,
    input logic              wen1_n,
    input logic              ren1_n,
    input logic              ren2_n,
    input logic [DATA_W-1:0] din,
    input logic [ADDR_W-1:0] empty_ofs,
    input logic [ADDR_W-1:0] full_ofs,
    input logic [DATA_W-1:0] rd_data,
    input sel_t              wr_sel
);

    // R5: offset read and offset write at once is unsupported
    p_no_rw_clash_r5: assert property (@(posedge wclk) disable iff (!rst_n)
        !(!load_n && !wen1_n && !ren1_n && !ren2_n));

    // R5: readback holds without a read step
    p_rd_hold_r5: assert property (@(posedge rclk) disable iff (!rst_n)
        !(!load_n && !ren1_n && !ren2_n) |=> $stable(rd_data));

    // R3: thresholds hold without a write step
    p_ofs_hold_r3: assert property (@(posedge wclk) disable iff (!rst_n)
        !(!load_n && !wen1_n) |=> ($stable(empty_ofs) && $stable(full_ofs)));

    // R1: last register wraps to first
    p_wrap_r1: assert property (@(posedge wclk) disable iff (!rst_n)
        (!load_n && !wen1_n && wr_sel == SEL_F_HI) |=> wr_sel == SEL_E_LO);

    // R2: write step at first register lands in empty low byte
    p_load_elo_r2: assert property (@(posedge wclk) disable iff (!rst_n)
        (!load_n && !wen1_n && wr_sel == SEL_E_LO) |=> empty_ofs[7:0] == $past(din[7:0]));

endmodule

bind offset_seq offset_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/offset_seq_bench.sv
`timescale 1ns/1ps
module offset_seq_bench;

    localparam int ADDR_W = 12;

    // op codes: 0 idle, 1 load write, 2 load no-op, 3 fifo write,
    //           4 offset read, 5 load with ren1 only, 6 fifo read
    localparam int VW = 3 + 9 + 12 + 12 + 9;
    localparam int NV = 15;
    localparam logic [VW-1:0] VEC [NV] = '{
        {3'd1, 9'h1A5, 12'h0A5, 12'h007, 9'h000},
        {3'd2, 9'h033, 12'h0A5, 12'h007, 9'h000},
        {3'd3, 9'h044, 12'h0A5, 12'h007, 9'h000},
        {3'd1, 9'h0FE, 12'hEA5, 12'h007, 9'h000},
        {3'd0, 9'h011, 12'hEA5, 12'h007, 9'h000},
        {3'd1, 9'h012, 12'hEA5, 12'h012, 9'h000},
        {3'd1, 9'h003, 12'hEA5, 12'h312, 9'h000},
        {3'd1, 9'h055, 12'hE55, 12'h312, 9'h000},
        {3'd4, 9'h000, 12'hE55, 12'h312, 9'h055},
        {3'd5, 9'h000, 12'hE55, 12'h312, 9'h055},
        {3'd6, 9'h000, 12'hE55, 12'h312, 9'h055},
        {3'd4, 9'h000, 12'hE55, 12'h312, 9'h0FE},
        {3'd4, 9'h000, 12'hE55, 12'h312, 9'h012},
        {3'd4, 9'h000, 12'hE55, 12'h312, 9'h003},
        {3'd4, 9'h000, 12'hE55, 12'h312, 9'h055}
    };

    logic wclk = 0, rclk = 0, rst_n = 0;
    logic load_n = 1, wen1_n = 1, ren1_n = 1, ren2_n = 1;
    logic [8:0] din = '0;
    logic [ADDR_W-1:0] empty_ofs, full_ofs;
    logic [8:0] rd_data;
    logic ofs_cycle;
    int n_chk = 0, n_bad = 0;

    offset_seq #(.ADDR_W(ADDR_W)) u_offset_seq (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .load_n(load_n),
        .wen1_n(wen1_n), .ren1_n(ren1_n), .ren2_n(ren2_n), .din(din),
        .empty_ofs(empty_ofs), .full_ofs(full_ofs), .rd_data(rd_data),
        .ofs_cycle(ofs_cycle)
    );

    always #2 wclk = ~wclk;
    initial begin
        #1;
        forever #2 rclk = ~rclk;
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic [8:0] d);
        din    = d;
        load_n = !(op == 3'd1 || op == 3'd2 || op == 3'd4 || op == 3'd5);
        wen1_n = !(op == 3'd1 || op == 3'd3);
        ren1_n = !(op == 3'd4 || op == 3'd5 || op == 3'd6);
        ren2_n = !(op == 3'd4 || op == 3'd6);
    endtask

    // drive at negedge wclk, check ofs_cycle, then sample after both edges
    task automatic step(input logic [2:0] op, input logic [8:0] d);
        drive(op, d);
        #1;
        check("R9 ofs_cycle", 16'(ofs_cycle), 16'(!load_n));
        @(negedge wclk);
    endtask

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        @(negedge wclk);
        @(negedge wclk);
        check("R6 reset empty", 16'(empty_ofs), 16'h007);
        check("R6 reset full", 16'(full_ofs), 16'h007);
        check("R6 reset rd_data", 16'(rd_data), 16'h000);
        rst_n = 1;
        @(negedge wclk);

        // table: R1 R2 R3 R5 R7 R8
        for (int i = 0; i < NV; i++) begin
            logic [2:0]  op;
            logic [8:0]  d, er;
            logic [11:0] ee, ef;
            {op, d, ee, ef, er} = VEC[i];
            step(op, d);
            check("R1/R2/R3/R8 empty_ofs", 16'(empty_ofs), 16'(ee));
            check("R1/R2/R3 full_ofs", 16'(full_ofs), 16'(ef));
            check("R5/R7 rd_data", 16'(rd_data), 16'(er));
        end

        // R6: reset with both pointers mid-sequence
        step(3'd1, 9'h077);   // write ptr now past E_LO
        step(3'd4, 9'h000);   // read ptr now past E_LO
        drive(3'd0, 9'h000);
        rst_n = 0;
        #1;
        check("R6 reset empty mid", 16'(empty_ofs), 16'h007);
        check("R6 reset full mid", 16'(full_ofs), 16'h007);
        check("R6 reset rd mid", 16'(rd_data), 16'h000);
        @(negedge wclk);
        rst_n = 1;
        @(negedge wclk);
        step(3'd1, 9'h021);
        check("R6 write ptr restarts", 16'(empty_ofs), 16'h021);
        step(3'd4, 9'h000);
        check("R6 read ptr restarts", 16'(rd_data), 16'h021);

        // R4: partial load resumes at next register
        step(3'd1, 9'h022);
        check("R4 second byte", 16'(empty_ofs), 16'h221);
        step(3'd0, 9'h000);
        step(3'd3, 9'h0AA);
        step(3'd1, 9'h030);
        check("R4 resume at full low", 16'(full_ofs), 16'h030);
        check("R4 empty untouched", 16'(empty_ofs), 16'h221);
        step(3'd4, 9'h000);
        check("R4 read resumes at empty high", 16'(rd_data), 16'h022);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule